// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects eight interrupt lines and raises one interrupt output toward a processor whenever an unmasked request outranks every line already being serviced. Each line is either edge-sensed or level-sensed, as chosen by a sense register. Priority rotates: an offset register decides which line ranks highest, and several commands move that offset. Software programs the block through a byte-wide register port with one address bit. An initialization sequence sets the vector base and the operating options. Command writes then handle end-of-service, priority changes, read selection, special masking and polling.

The processor takes an interrupt with a single-cycle `ack` strobe. During that cycle `ack_vector` carries the vector base in bits 7:3 and the winning line in bits 2:0. In the same strobe the block records the line as in service, unless it is in automatic end-of-service mode. The strobe also drops the stored request of an edge-sensed line. All pins are plain control and status signals. The block keeps no buffer and has no handshake, so `ack`, register reads and register writes are taken in the cycle they are presented, and software issues at most one of them per cycle.

Top module: `irqc8_core`

## Requirements
- R1: After reset the mask, request, in-service, sense and offset state is zero, `int_out` is 0, reads at address 0 and 1 return 0x00, and `ack_vector` is 0x07.
- R2: For an edge-sensed line (sense bit 0), the request bit is set one cycle after the input goes from 0 to 1 compared with the previous cycle's level. A held-high input sets it only once. A low input clears no request bit.
- R3: For a level-sensed line (sense bit 1), the request bit equals the input level of the previous cycle. An acknowledge, a poll or an end-of-service command does not clear it.
- R4: A write on `sense_we` loads the sense register with `sense_wdata AND SENSE_WMASK` (default 0xF8), and `sense_rdata` returns it.
- R5: A write at address 0 with data bit 4 set starts initialization. It clears the mask, request, in-service, remembered input levels, offset, auto-rotate, read-select, special-mask, nested, automatic end-of-service and poll state. The next address-1 writes are then: the base (bits 7:3 kept); a cascade word, skipped when bit 1 of the starting write was 1; and an option word, taken only when bit 0 of the starting write was 1, where bit 4 sets nested mode and bit 1 sets automatic end-of-service.
- R6: Outside initialization, an address-1 write loads the mask register, and an address-1 read returns it. A masked line never drives `int_out`.
- R7: Rank of line L = (L − offset) mod 8, with rank 0 highest. `int_out` is 1 when the best unmasked request ranks strictly above the best in-service line. Under special mask, masked in-service lines are ignored for this test. In nested mode (with IS_MASTER) in-service line CASCADE_LINE is ignored.
- R8: On `ack`, `ack_vector` = {base, winning line}. The in-service bit of that line is set unless automatic end-of-service is on. Its request is cleared only if edge-sensed. With automatic end-of-service and auto-rotate both on, the offset becomes line+1. When nothing is pending the vector carries line 7 and no state changes.
- R9: An address-0 write with bit 4 = 0 and bit 3 = 1 is a mode write. Bit 1 enables loading read-select from bit 0, bit 6 enables loading special mask from bit 5, and bit 2 arms a poll. An address-0 read returns the in-service register when read-select is 1, otherwise the request register.
- R10: An address-0 write with bits 4 and 3 both 0 is an operation with code = bits 7:5. Code 0 clears auto-rotate, code 4 sets it, code 2 does nothing, and code 6 sets the offset to (bits 2:0 + 1) mod 8.
- R11: Code 1 clears the highest-ranked in-service bit. Code 5 does the same and sets the offset to (cleared line + 1) mod 8. With nothing in service, neither code changes anything.
- R12: Code 3 clears in-service bit [bits 2:0]. Code 7 also sets the offset to (bits 2:0 + 1) mod 8.
- R13: An armed poll turns the next address-0 read into 0x80 OR line when an interrupt is pending (that line's request is cleared if edge-sensed and its in-service bit is cleared), or 0x07 when none is pending. Either read disarms the poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (side effects only for poll) |
| reg_addr | input | 1 | Register address bit |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from state |
| sense_we | input | 1 | Sense register write strobe |
| sense_wdata | input | 8 | Sense register write data (1 = level) |
| sense_rdata | output | 8 | Sense register contents |
| irq_in | input | 8 | Interrupt input lines |
| int_out | output | 1 | Interrupt request toward the processor |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_vector | output | 8 | Vector taken by an acknowledge in this cycle |

## Verification
The bench goes after nested service, where a higher-ranked line must interrupt a lower one already in service, and a non-specific end must clear the higher one first. A design that picks by line number instead of rank fails this once the offset moves. It holds edge inputs high across an acknowledge and expects no second request, which catches a design that retriggers on level. It also acknowledges a level-sensed line and expects the request to stay set, which catches one that clears it. Polls with and without a pending line, automatic end-of-service with rotation, and an acknowledge with nothing pending check the vector's low bits and the offset. A wrong offset update shows up as the wrong line winning on a later acknowledge.

// File: rtl/irqc8_pkg.sv
package irqc8_pkg;
  localparam int N_LINES = 8;
  localparam int LINE_W  = $clog2(N_LINES);
  localparam int BASE_W  = 8 - LINE_W;

  typedef logic [N_LINES-1:0] lvec_t;
  typedef logic [LINE_W-1:0]  line_t;

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_OPT} init_st_t;

  localparam logic [2:0] OP_ROT_OFF   = 3'd0;
  localparam logic [2:0] OP_END       = 3'd1;
  localparam logic [2:0] OP_NOP       = 3'd2;
  localparam logic [2:0] OP_END_AT    = 3'd3;
  localparam logic [2:0] OP_ROT_ON    = 3'd4;
  localparam logic [2:0] OP_END_ROT   = 3'd5;
  localparam logic [2:0] OP_SET_PRI   = 3'd6;
  localparam logic [2:0] OP_END_AT_RO = 3'd7;
endpackage

// File: rtl/irqc8_req.sv
module irqc8_req
  import irqc8_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lvec_t irq_in,
  input  lvec_t lvl_sel,
  input  logic  clr_all,
  input  lvec_t clr_edge,
  output lvec_t req_q
);
  lvec_t last_q;
  lvec_t rise;

  assign rise = irq_in & ~last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      last_q <= '0;
    end else if (clr_all) begin
      req_q  <= '0;
      last_q <= '0;
    end else begin
      last_q <= irq_in;
      req_q  <= (lvl_sel & irq_in) | (~lvl_sel & ((req_q & ~clr_edge) | rise));
    end
  end

  // R3: level-sensed bits mirror the previous cycle's input
  assert_level_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> ((req_q & $past(lvl_sel)) == ($past(irq_in) & $past(lvl_sel))));

  // R2: a newly set edge bit needs the input high in the cycle before
  assert_edge_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> ((req_q & ~$past(req_q) & ~$past(lvl_sel) & ~$past(irq_in)) == '0));

  // R5: start of initialization empties the request register
  assert_init_clears_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (req_q == '0));
endmodule

// File: rtl/irqc8_prio.sv
module irqc8_prio
  import irqc8_pkg::*;
(
  input  lvec_t mask,
  input  line_t off,
  output logic  found,
  output line_t rank
);
  lvec_t rot;

  for (genvar r = 0; r < N_LINES; r++) begin : g_rot
    line_t src;
    assign src    = line_t'(r) + off;
    assign rot[r] = mask[src];
  end

  always_comb begin
    found = 1'b0;
    rank  = '0;
    for (int r = N_LINES - 1; r >= 0; r--) begin
      if (rot[r]) begin
        found = 1'b1;
        rank  = line_t'(r);
      end
    end
  end

  // R7: the chosen rank maps back to a set bit of the input mask
  always_comb begin
    if (found) begin
      assert_pick_is_set_R7: assert (mask[line_t'(rank + off)])
        else $error("picked line not in mask");
    end
  end
endmodule

// File: rtl/irqc8_core.sv
module irqc8_core
  import irqc8_pkg::*;
#(
  parameter logic [7:0] SENSE_WMASK  = 8'hF8,
  parameter bit         IS_MASTER    = 1'b1,
  parameter int         CASCADE_LINE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sense_we,
  input  logic [7:0] sense_wdata,
  output logic [7:0] sense_rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       ack,
  output logic [7:0] ack_vector
);
  lvec_t req_q, svc_q, mask_q, sense_q;
  line_t off_q, off_n;
  logic [BASE_W-1:0] base_q;
  logic auto_end, auto_rot, rsel, smask, nested, poll_q, want_opt, no_casc;
  init_st_t st_q;

  // write decode
  logic  wr_lo, wr_hi, wr_init, wr_mode, wr_op;
  logic [2:0] op;
  line_t wline;
  assign wr_lo   = reg_we && !reg_addr;
  assign wr_hi   = reg_we && reg_addr;
  assign wr_init = wr_lo && reg_wdata[4];
  assign wr_mode = wr_lo && !reg_wdata[4] && reg_wdata[3];
  assign wr_op   = wr_lo && !reg_wdata[4] && !reg_wdata[3];
  assign op      = reg_wdata[7:5];
  assign wline   = reg_wdata[LINE_W-1:0];

  // priority resolution
  lvec_t req_view, svc_view, casc_bit;
  logic  req_found, svc_found, end_found;
  line_t req_rank, svc_rank, end_rank, req_line, end_line;

  assign casc_bit = (nested && IS_MASTER) ? (lvec_t'(1) << CASCADE_LINE) : '0;
  assign req_view = req_q & ~mask_q;
  assign svc_view = svc_q & ~(smask ? mask_q : '0) & ~casc_bit;

  irqc8_prio u_req_pick (.mask(req_view), .off(off_q), .found(req_found), .rank(req_rank));
  irqc8_prio u_svc_pick (.mask(svc_view), .off(off_q), .found(svc_found), .rank(svc_rank));
  irqc8_prio u_end_pick (.mask(svc_q),    .off(off_q), .found(end_found), .rank(end_rank));

  logic pending;
  assign req_line = req_rank + off_q;
  assign end_line = end_rank + off_q;
  assign pending  = req_found && (!svc_found || (req_rank < svc_rank));

  assign int_out     = pending;
  assign ack_vector  = {base_q, pending ? req_line : line_t'(N_LINES - 1)};
  assign sense_rdata = sense_q;

  // poll and acknowledge
  logic  poll_rd, take;
  lvec_t take_bit, svc_set, svc_clr, end_clr;
  assign poll_rd  = reg_re && !reg_addr && poll_q;
  assign take     = (ack || poll_rd) && pending;
  assign take_bit = take ? (lvec_t'(1) << req_line) : '0;
  assign svc_set  = (ack && pending && !auto_end) ? take_bit : '0;

  always_comb begin
    end_clr = '0;
    if (wr_op) begin
      unique case (op)
        OP_END, OP_END_ROT:       if (end_found) end_clr = lvec_t'(1) << end_line;
        OP_END_AT, OP_END_AT_RO:  end_clr = lvec_t'(1) << wline;
        default:                  end_clr = '0;
      endcase
    end
  end
  assign svc_clr = end_clr | (poll_rd ? take_bit : '0);

  always_comb begin
    off_n = off_q;
    if (wr_op) begin
      unique case (op)
        OP_END_ROT:               if (end_found) off_n = end_line + line_t'(1);
        OP_SET_PRI, OP_END_AT_RO: off_n = wline + line_t'(1);
        default:                  off_n = off_q;
      endcase
    end else if (ack && pending && auto_end && auto_rot) begin
      off_n = req_line + line_t'(1);
    end
  end

  // read data
  always_comb begin
    if (reg_addr)    reg_rdata = mask_q;
    else if (poll_q) reg_rdata = pending ? {1'b1, {(BASE_W-1){1'b0}}, req_line} : 8'h07;
    else if (rsel)   reg_rdata = svc_q;
    else             reg_rdata = req_q;
  end

  irqc8_req u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl_sel(sense_q),
    .clr_all(wr_init), .clr_edge(take_bit), .req_q(req_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else if (wr_init) svc_q <= '0;
    else svc_q <= (svc_q & ~svc_clr) | svc_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0; sense_q <= '0; off_q <= '0; base_q <= '0;
      auto_end <= 1'b0; auto_rot <= 1'b0; rsel <= 1'b0; smask <= 1'b0;
      nested <= 1'b0; poll_q <= 1'b0; want_opt <= 1'b0; no_casc <= 1'b0;
      st_q <= ST_RUN;
    end else begin
      if (sense_we) sense_q <= sense_wdata & SENSE_WMASK;
      if (wr_init) begin
        mask_q <= '0; off_q <= '0; auto_end <= 1'b0; auto_rot <= 1'b0;
        rsel <= 1'b0; smask <= 1'b0; nested <= 1'b0; poll_q <= 1'b0;
        want_opt <= reg_wdata[0]; no_casc <= reg_wdata[1];
        st_q <= ST_BASE;
      end else begin
        off_q <= off_n;
        if (reg_re && !reg_addr) poll_q <= 1'b0;
        if (wr_mode) begin
          if (reg_wdata[1]) rsel  <= reg_wdata[0];
          if (reg_wdata[6]) smask <= reg_wdata[5];
          if (reg_wdata[2]) poll_q <= 1'b1;
        end
        if (wr_op) begin
          if (op == OP_ROT_OFF) auto_rot <= 1'b0;
          if (op == OP_ROT_ON)  auto_rot <= 1'b1;
        end
        if (wr_hi) begin
          unique case (st_q)
            ST_RUN:  mask_q <= reg_wdata;
            ST_BASE: begin
              base_q <= reg_wdata[7:LINE_W];
              st_q   <= !no_casc ? ST_CASC : (want_opt ? ST_OPT : ST_RUN);
            end
            ST_CASC: st_q <= want_opt ? ST_OPT : ST_RUN;
            ST_OPT: begin
              nested   <= reg_wdata[4];
              auto_end <= reg_wdata[1];
              st_q     <= ST_RUN;
            end
            default: st_q <= ST_RUN;
          endcase
        end
      end
    end
  end

  // R7: the interrupt output needs an unmasked request
  assert_int_has_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (req_view != '0));

  // R5: start of initialization clears mask and service and enters the base step
  assert_init_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_init |=> (mask_q == '0 && svc_q == '0 && st_q == ST_BASE));

  // R8: automatic end-of-service leaves the in-service register unchanged
  assert_auto_end_keeps_svc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && auto_end && !reg_we && !reg_re) |=> (svc_q == $past(svc_q)));

  // R8: a taken acknowledge adds exactly one in-service bit
  assert_ack_sets_svc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !auto_end && !nested && !reg_we && !reg_re)
      |=> ($countones(svc_q) == $countones($past(svc_q)) + 1));

  // R12: a specific end clears the named in-service bit
  assert_specific_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op && op[1:0] == 2'b11 && !ack) |=> !svc_q[$past(wline)]);

  // R13: any address-0 read disarms a poll
  assert_poll_once_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && !reg_addr && !reg_we) |=> !poll_q);
endmodule

// File: tb/irqc8_core_bench.sv
`timescale 1ns/1ps
module irqc8_core_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_re = 0, reg_addr = 0, sense_we = 0, ack = 0;
  logic [7:0] reg_wdata = 0, sense_wdata = 0, irq_in = 0;
  logic [7:0] reg_rdata, sense_rdata, ack_vector;
  logic int_out;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irqc8_core u_irqc8_core (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sense_we(sense_we),
    .sense_wdata(sense_wdata), .sense_rdata(sense_rdata), .irq_in(irq_in),
    .int_out(int_out), .ack(ack), .ack_vector(ack_vector)
  );

  // expected state, kept from the requirements
  logic [7:0] m_req = 0, m_svc = 0, m_mask = 0, m_sense = 0, m_last = 0;
  logic [2:0] m_off = 0;
  logic [4:0] m_base = 0;
  bit m_aend = 0, m_arot = 0, m_rsel = 0, m_smask = 0, m_nest = 0, m_poll = 0;
  bit m_opt = 0, m_single = 0;
  int m_st = 0; // 0 run, 1 base, 2 cascade, 3 option

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rank_of(logic [7:0] m, logic [2:0] o);
    for (int r = 0; r < 8; r++) if (m[(r + int'(o)) % 8]) return r;
    return 8;
  endfunction

  task automatic m_eval(output bit p, output logic [2:0] l);
    logic [7:0] sv;
    int rr, rs;
    sv = m_svc;
    if (m_smask) sv = sv & ~m_mask;
    if (m_nest) sv[2] = 1'b0;
    rr = rank_of(m_req & ~m_mask, m_off);
    rs = rank_of(sv, m_off);
    p = (rr < 8) && (rr < rs);
    l = 3'((rr + int'(m_off)) % 8);
  endtask

  task automatic m_step(bit p, logic [2:0] l);
    logic [7:0] n_req, n_svc, d;
    logic [2:0] n_off;
    bit rd_lo, take;
    int r;
    d = reg_wdata;
    n_svc = m_svc;
    n_off = m_off;
    rd_lo = reg_re && !reg_addr;
    take = (ack || (rd_lo && m_poll)) && p;
    for (int i = 0; i < 8; i++) begin
      if (m_sense[i]) n_req[i] = irq_in[i];
      else n_req[i] = (m_req[i] && !(take && int'(l) == i)) || (irq_in[i] && !m_last[i]);
    end
    if (ack && p && !m_aend) n_svc[l] = 1'b1;
    if (ack && p && m_aend && m_arot) n_off = l + 3'd1;
    if (rd_lo && m_poll && p) n_svc[l] = 1'b0;
    if (rd_lo) m_poll = 0;
    if (reg_we && !reg_addr) begin
      if (d[4]) begin
        n_req = 0; n_svc = 0; m_mask = 0; n_off = 0; m_aend = 0; m_arot = 0;
        m_rsel = 0; m_smask = 0; m_nest = 0; m_poll = 0;
        m_opt = d[0]; m_single = d[1]; m_st = 1;
      end else if (d[3]) begin
        if (d[1]) m_rsel = d[0];
        if (d[6]) m_smask = d[5];
        if (d[2]) m_poll = 1;
      end else begin
        case (d[7:5])
          3'd0: m_arot = 0;
          3'd4: m_arot = 1;
          3'd1, 3'd5: begin
            r = rank_of(m_svc, m_off);
            if (r < 8) begin
              n_svc[(r + int'(m_off)) % 8] = 1'b0;
              if (d[7:5] == 3'd5) n_off = 3'((r + int'(m_off) + 1) % 8);
            end
          end
          3'd3: n_svc[d[2:0]] = 1'b0;
          3'd7: begin n_svc[d[2:0]] = 1'b0; n_off = d[2:0] + 3'd1; end
          3'd6: n_off = d[2:0] + 3'd1;
          default: ;
        endcase
      end
    end
    if (reg_we && reg_addr) begin
      case (m_st)
        0: m_mask = d;
        1: begin m_base = d[7:3]; m_st = !m_single ? 2 : (m_opt ? 3 : 0); end
        2: m_st = m_opt ? 3 : 0;
        default: begin m_nest = d[4]; m_aend = d[1]; m_st = 0; end
      endcase
    end
    if (sense_we) m_sense = sense_wdata & 8'hF8;
    m_last = (reg_we && !reg_addr && d[4]) ? 8'h00 : irq_in;
    m_req = n_req;
    m_svc = n_svc;
    m_off = n_off;
  endtask

  // inputs are driven at the falling edge; sample 1 ns later, then step
  task automatic tick(string tag = "R9", int exp_rd = -1, int exp_vec = -1);
    bit p;
    logic [2:0] l;
    logic [7:0] er;
    #1;
    m_eval(p, l);
    chk("R7", {7'd0, int_out}, {7'd0, p});
    chk("R8", ack_vector, {m_base, p ? l : 3'd7});
    chk("R4", sense_rdata, m_sense);
    if (reg_re) begin
      er = reg_addr ? m_mask : m_poll ? (p ? {5'b10000, l} : 8'h07) : (m_rsel ? m_svc : m_req);
      chk(tag, reg_rdata, er);
      if (exp_rd >= 0) chk(tag, reg_rdata, exp_rd[7:0]);
    end
    if (exp_vec >= 0) chk(tag, ack_vector, exp_vec[7:0]);
    m_step(p, l);
    @(negedge clk);
  endtask

  task automatic clr_strobes();
    reg_we = 0; reg_re = 0; ack = 0; sense_we = 0;
  endtask

  task automatic wr(bit a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; tick(); clr_strobes();
  endtask

  task automatic rd(bit a, int exp, string tag);
    reg_re = 1; reg_addr = a; tick(tag, exp); clr_strobes();
  endtask

  task automatic take_ack(int exp, string tag);
    ack = 1; tick(tag, -1, exp); clr_strobes();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", {7'd0, int_out}, 8'h00);
    chk("R1", ack_vector, 8'h07);
    chk("R1", sense_rdata, 8'h00);
    @(negedge clk);
    rd(1, 8'h00, "R1");
    rd(0, 8'h00, "R1");

    // R5 init: cascade word and option word both expected
    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04); wr(1, 8'h01);

    // R2 edge request, R8 vector, R12 specific end
    irq_in = 8'h08; idle(1);
    take_ack(8'h43, "R8");
    idle(2);
    chk("R2", {7'd0, int_out}, 8'h00); // held high: no second request
    wr(0, 8'h0B);
    rd(0, 8'h08, "R9");
    wr(0, 8'h63);
    rd(0, 8'h00, "R12");
    idle(2);
    chk("R2", {7'd0, int_out}, 8'h00);
    irq_in = 8'h00; idle(1);
    chk("R2", {7'd0, int_out}, 8'h00); // low level kept no new request

    // R11 nested service: line 3 then line 0
    irq_in = 8'h08; idle(1); take_ack(8'h43, "R8");
    irq_in = 8'h09; idle(1); take_ack(8'h40, "R7");
    irq_in = 8'h00;
    rd(0, 8'h09, "R11");
    wr(0, 8'h20);
    rd(0, 8'h08, "R11");
    wr(0, 8'h20);
    rd(0, 8'h00, "R11");

    // R4 sense mask, R3 level line stays requested after ack
    sense_we = 1; sense_wdata = 8'hFF; tick(); clr_strobes();
    chk("R4", sense_rdata, 8'hF8);
    irq_in = 8'h20; idle(1);
    take_ack(8'h45, "R8");
    wr(0, 8'h0A);
    rd(0, 8'h20, "R3");
    wr(0, 8'h20);
    irq_in = 8'h00; idle(1);
    rd(0, 8'h00, "R3");

    // R6 mask
    wr(1, 8'h02);
    rd(1, 8'h02, "R6");
    irq_in = 8'h02; idle(2);
    chk("R6", {7'd0, int_out}, 8'h00);
    wr(1, 8'h00);
    chk("R6", {7'd0, int_out}, 8'h01);
    take_ack(8'h41, "R6");
    irq_in = 8'h00;
    wr(0, 8'h20);

    // R10 set priority, R12 rotating specific end
    wr(0, 8'hC4); // offset 5
    irq_in = 8'h42; idle(1);
    take_ack(8'h46, "R10");
    irq_in = 8'h00;
    wr(0, 8'hE6); // offset 7
    idle(1);
    take_ack(8'h41, "R12");
    wr(0, 8'hA0); // R11 rotating end clears line 1, offset 2
    irq_in = 8'h81; idle(1);
    take_ack(8'h47, "R11");
    irq_in = 8'h00;
    wr(0, 8'h67);
    take_ack(8'h40, "R10");
    wr(0, 8'h20);
    wr(0, 8'hC7); // offset 0
    wr(0, 8'h40); // code 2 does nothing
    chk("R10", {7'd0, int_out}, 8'h00);

    // R13 poll with and without pending line
    irq_in = 8'h04; idle(1);
    wr(0, 8'h0C);
    rd(0, 8'h82, "R13");
    chk("R13", {7'd0, int_out}, 8'h00);
    wr(0, 8'h0C);
    rd(0, 8'h07, "R13");
    irq_in = 8'h00;

    // R5 second init: no cascade word, automatic end with rotation
    wr(0, 8'h13);
    rd(1, 8'h00, "R5");
    wr(1, 8'h80); wr(1, 8'h02);
    sense_we = 1; sense_wdata = 8'h00; tick(); clr_strobes();
    wr(0, 8'h80);
    irq_in = 8'h10; idle(1);
    take_ack(8'h84, "R8");
    irq_in = 8'h00;
    wr(0, 8'h0B);
    rd(0, 8'h00, "R8");
    irq_in = 8'h81; idle(1);
    take_ack(8'h87, "R8"); // offset 5: line 7 outranks line 0
    irq_in = 8'h00;
    take_ack(8'h80, "R8");
    take_ack(8'h87, "R8"); // nothing pending

    // constrained random mix
    for (int n = 0; n < 6000; n++) begin
      int sel;
      logic [7:0] d;
      if ($urandom_range(2) == 0) irq_in = irq_in ^ (8'h01 << $urandom_range(7));
      sel = $urandom_range(99);
      d = 8'($urandom());
      if (sel < 15) ack = 1;
      else if (sel < 27) begin reg_re = 1; reg_addr = 0; end
      else if (sel < 32) begin reg_re = 1; reg_addr = 1; end
      else if (sel < 50) begin
        if ($urandom_range(19) != 0) d[4] = 1'b0;
        reg_we = 1; reg_addr = 0; reg_wdata = d;
      end else if (sel < 56) begin reg_we = 1; reg_addr = 1; reg_wdata = d; end
      else if (sel < 59) begin sense_we = 1; sense_wdata = d; end
      tick("R9");
      clr_strobes();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule